// File: doc/BRIEF.md
# Binary FSK Sine Modulator

This block turns a serial bit stream into signed sine samples for a digital-to-analogue converter. Every data bit occupies twenty sample clocks. A logic one is sent as a single full cycle of the low tone, which has twenty samples per cycle. A logic zero is sent as two full cycles of the high tone, which has ten samples per cycle. With a 40 MHz sample clock and a 2 MHz bit rate, the two tones are 2 MHz and 4 MHz.

The data bit is captured once, at the first sample clock of each bit period. The sample position restarts at every bit boundary. Because of this, both tones begin and end each bit at phase zero, and the waveform has no step at a tone change. Both tones are read from one built-in quarter-symmetric sine table. The low tone walks the table one entry per clock. The high tone walks it two entries per clock.

The output is two's complement and centred on zero. It comes with a valid strobe. When the enable input is low, the output sits at mid-scale.

Top module: `fsk_sine_mod`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release with en low, samp_o is 0 and samp_vld_o is 0.
- R2: For a bit captured as 1, the twenty samples of the bit are S(k) for positions k = 0..19. S(k) is round(32767·sin(2πk/20)) taken as a 16-bit signed value and arithmetically shifted right by 16−SAMP_W. With the default SAMP_W of 12, the peak at k = 5 is 2047 and the trough at k = 15 is −2048.
- R3: For a bit captured as 0, the sample at position k is S((2k) mod 20). This gives two full cycles per bit, and the sample at position 5 is 0.
- R4: bit_in is sampled only on the clock edge at position 0 of a bit. Changes on bit_in at positions 1..19 have no effect on that bit's samples.
- R5: Every bit begins at position 0 with sample value 0, so the tone changes only at bit boundaries.
- R6: The sample for a position is registered on the clock edge that ends that position's cycle. It is visible on samp_o for the following cycle, which is one cycle of latency.
- R7: A clock edge with en low sets samp_o to 0 and samp_vld_o to 0. It also aborts the current bit, so the next edge with en high starts a new bit at position 0 and samples bit_in.
- R8: samp_vld_o is 1 in the cycle after every edge at which en was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces mid-scale output |
| bit_in | input | 1 | Serial data bit, captured at bit position 0 |
| samp_o | output | SAMP_W | Signed sine sample |
| samp_vld_o | output | 1 | Sample valid strobe |

## Verification
Every result of this block is due exactly one edge after the inputs that cause it. This covers a sample, its valid flag, the mid-scale value after en falls, and the restart after en rises. The bench drives en and bit_in on the falling edge and lets one rising edge pass. It compares on the next falling edge, against a reference that advances its own bit position by one per edge. The captured bit is modelled as changing only at position 0. Random per-cycle changes of bit_in inside a bit therefore test R4 on every cycle where they occur.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    // Samples per data bit (sample clock / bit rate)
    localparam int BIT_LEN = 20;
    localparam int CNT_W   = $clog2(BIT_LEN);
    localparam int TBL_W   = 16;

    // Full-scale sine over one 20-sample period, amplitude 32767
    function automatic logic signed [TBL_W-1:0] sine_tbl(input logic [CNT_W-1:0] k);
        logic [CNT_W-1:0]        q;
        logic signed [TBL_W-1:0] mag;
        // fold into the first half-period, then mirror about its peak
        q = (k >= CNT_W'(BIT_LEN/2)) ? k - CNT_W'(BIT_LEN/2) : k;
        if (q > CNT_W'(BIT_LEN/4)) q = CNT_W'(BIT_LEN/2) - q;
        case (q)
            5'd1:    mag = 16'sd10126;
            5'd2:    mag = 16'sd19260;
            5'd3:    mag = 16'sd26509;
            5'd4:    mag = 16'sd31163;
            5'd5:    mag = 16'sd32767;
            default: mag = 16'sd0;
        endcase
        return (k >= CNT_W'(BIT_LEN/2)) ? -mag : mag;
    endfunction

endpackage

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer
    import fsk_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             at_start
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_LEN - 1);

    always_comb begin
        at_start = (cnt_q == '0);
        cnt_nxt  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/fsk_phase_map.sv
module fsk_phase_map
    import fsk_pkg::*;
(
    input  logic             tone_lo,
    input  logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] idx
);
    logic [CNT_W:0] dbl;

    always_comb begin
        dbl = {pos, 1'b0};
        if (dbl >= (CNT_W+1)'(BIT_LEN))
            dbl = dbl - (CNT_W+1)'(BIT_LEN);
        idx = tone_lo ? pos : dbl[CNT_W-1:0];
    end
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
    import fsk_pkg::*;
#(
    parameter int SAMP_W = 12
) (
    input  logic [CNT_W-1:0]         idx,
    output logic signed [SAMP_W-1:0] samp
);
    localparam int SHIFT = TBL_W - SAMP_W;

    logic signed [TBL_W-1:0] full;
    logic signed [TBL_W-1:0] scaled;

    generate
        if (SHIFT > 0) begin : g_shift
            always_comb scaled = full >>> SHIFT;
        end else begin : g_pass
            always_comb scaled = full;
        end
    endgenerate

    always_comb begin
        full = sine_tbl(idx);
        samp = scaled[SAMP_W-1:0];
    end
endmodule

// File: rtl/fsk_sine_mod.sv
module fsk_sine_mod
    import fsk_pkg::*;
#(
    parameter int SAMP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     bit_in,
    output logic signed [SAMP_W-1:0] samp_o,
    output logic                     samp_vld_o
);
    typedef struct packed {
        logic [CNT_W-1:0]         cnt;
        logic                     bit_hold;
        logic signed [SAMP_W-1:0] samp;
        logic                     vld;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0]         cnt_nxt;
    logic                     at_start;
    logic                     cur_bit;
    logic [CNT_W-1:0]         idx;
    logic signed [SAMP_W-1:0] rom_samp;

    // names seen by the bound checker
    logic [CNT_W-1:0] cnt_w;
    logic             bit_hold_w;

    fsk_bit_timer u_timer (
        .cnt_q    (st_q.cnt),
        .cnt_nxt  (cnt_nxt),
        .at_start (at_start)
    );

    fsk_phase_map u_phase (
        .tone_lo (cur_bit),
        .pos     (st_q.cnt),
        .idx     (idx)
    );

    fsk_sine_rom #(.SAMP_W(SAMP_W)) u_rom (
        .idx  (idx),
        .samp (rom_samp)
    );

    always_comb begin
        cur_bit = at_start ? bit_in : st_q.bit_hold;
        st_d    = st_q;
        if (!en) begin
            st_d.cnt  = '0;
            st_d.samp = '0;
            st_d.vld  = 1'b0;
        end else begin
            st_d.cnt      = cnt_nxt;
            st_d.bit_hold = cur_bit;
            st_d.samp     = rom_samp;
            st_d.vld      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign samp_o     = st_q.samp;
    assign samp_vld_o = st_q.vld;
    assign cnt_w      = st_q.cnt;
    assign bit_hold_w = st_q.bit_hold;
endmodule

// File: rtl/fsk_sine_mod_chk.sv
module fsk_sine_mod_chk
    import fsk_pkg::*;
#(
    parameter int SAMP_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     en,
    input logic signed [SAMP_W-1:0] samp_o,
    input logic                     samp_vld_o,
    input logic [CNT_W-1:0]         cnt_i,
    input logic                     bit_hold_i
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_LEN - 1);
    localparam logic [CNT_W-1:0] QTR  = CNT_W'(BIT_LEN / 4);

    AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (samp_o == '0 && !samp_vld_o)); // R7

    AST_VALID_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> samp_vld_o); // R8

    AST_BIT_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_i == '0) |=> samp_o == '0); // R5

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_i != '0) |=> $stable(bit_hold_i)); // R4

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_i == LAST) |=> cnt_i == '0); // R2

    AST_HIGH_TONE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_i == QTR && !bit_hold_i) |=> samp_o == '0); // R3
endmodule

bind fsk_sine_mod fsk_sine_mod_chk #(.SAMP_W(SAMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .samp_o     (samp_o),
    .samp_vld_o (samp_vld_o),
    .cnt_i      (cnt_w),
    .bit_hold_i (bit_hold_w)
);

// File: tb/fsk_sine_mod_tb_top.sv
module fsk_sine_mod_tb_top;
    localparam int SAMP_W = 12;
    localparam int NBIT   = 20;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     en = 1'b0;
    logic                     bit_in = 1'b0;
    logic signed [SAMP_W-1:0] samp_o;
    logic                     samp_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int m_pos = 0;
    bit m_bit = 1'b0;
    int exp_samp = 0;
    bit exp_vld = 1'b0;

    always #2 clk = ~clk;

    fsk_sine_mod #(.SAMP_W(SAMP_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .bit_in     (bit_in),
        .samp_o     (samp_o),
        .samp_vld_o (samp_vld_o)
    );

    function automatic int sinref(input int k);
        int v;
        logic signed [15:0] s16;
        logic signed [15:0] sh;
        v   = int'(32767.0 * $sin(2.0 * 3.14159265358979 * real'(k) / real'(NBIT)));
        s16 = 16'(v);
        sh  = s16 >>> (16 - SAMP_W);
        return int'(sh);
    endfunction

    task automatic check(input int act, input int expv, input string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // one sample cycle: drive on falling edge, compare on the next falling edge
    task automatic step(input bit e, input bit b, input string tag);
        int k;
        bit cur;
        en = e;
        bit_in = b;
        @(posedge clk);
        if (!e) begin
            m_pos = 0; exp_samp = 0; exp_vld = 1'b0;
        end else begin
            cur = (m_pos == 0) ? b : m_bit;
            m_bit = cur;
            k = cur ? m_pos : (2 * m_pos) % NBIT;
            exp_samp = sinref(k);
            exp_vld = 1'b1;
            m_pos = (m_pos + 1) % NBIT;
        end
        @(negedge clk);
        check(int'(samp_o), exp_samp, tag);
        check(int'(samp_vld_o), int'(exp_vld), "R8");
    endtask

    task automatic send_bit(input bit b, input bit noisy, input string tag);
        for (int i = 0; i < NBIT; i++)
            step(1'b1, (i == 0 || !noisy) ? b : 1'($urandom), tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_F5C1));
        repeat (3) @(negedge clk);
        check(int'(samp_o), 0, "R1");
        check(int'(samp_vld_o), 0, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");

        // first bit: latency and peak of the low tone
        step(1'b1, 1'b1, "R6");
        check(int'(samp_o), 0, "R6");
        for (int i = 1; i < NBIT; i++) begin
            step(1'b1, 1'b1, "R2");
            if (i == 5)  check(int'(samp_o), 2047, "R2");
            if (i == 15) check(int'(samp_o), -2048, "R2");
        end
        send_bit(1'b0, 1'b0, "R3");
        send_bit(1'b1, 1'b0, "R5");
        send_bit(1'b0, 1'b0, "R5");
        // bit_in toggles inside the bit
        send_bit(1'b1, 1'b1, "R4");
        send_bit(1'b0, 1'b1, "R4");

        // abort mid-bit and restart
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, "R2");
        step(1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, "R7");
        for (int i = 1; i < NBIT; i++) step(1'b1, 1'b1, "R7");

        // random traffic with noise and occasional enable drops
        for (int n = 0; n < 3000; n++) begin
            bit e;
            e = ($urandom % 50) != 0;
            step(e, 1'($urandom), "R4");
        end
        for (int n = 0; n < 60; n++) send_bit(1'($urandom), 1'b1, "R5");

        step(1'b0, 1'b0, "R7");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule